// File: doc/BRIEF.md
# CPU Register and Memory Bridge

This block sits between a 16-bit host CPU and two targets: a bank of eight internal 16-bit registers and an external backend memory port. Every CPU input is sampled, and every output driven, on the one master clock. A chip-select qualifies each access. A read strobe and two active-low byte-lane write strobes give its direction. A target select picks either a register, numbered by the low address bits, or the backend memory, which gets the full 16-bit address.

Register accesses finish at once and never stall the CPU. Backend accesses use a request, grant and wait handshake. The bridge holds the CPU wait output low while the transfer runs. The stall lasts at least a fixed number of cycles, which differs between reads and writes, and is stretched by a late grant or a held backend wait. If the backend has not finished within a bounded number of request cycles, the transfer is abandoned. A sticky failure flag and an interrupt request are then raised, and both stay set until the CPU writes the clear register. A data-enable output marks the cycles in which the bridge drives read data, so that it can steer an external tristate buffer.

Top module: `hb_cpu_bridge`

## Requirements
- R1: While `rst_n` is low and on the first cycle after it, `cpu_wait_n`, `mem_req_n`, `mem_rd_n` and both `mem_wr_n` bits are 1, and `cpu_den`, `cpu_dout`, `mem_fail` and `irq` are 0.
- R2: A register write with `cpu_mem_sel`=0 targets register `cpu_addr[2:0]`. `cpu_wr_n[1]`=0 updates bits 15:8 and `cpu_wr_n[0]`=0 updates bits 7:0. A lane whose strobe is 1 keeps its value. Registers 2 to 7 read back what was written.
- R3: `cpu_wait_n` stays 1 for register accesses. A register read presents its data on `cpu_dout` with `cpu_den`=1 in the cycle after the strobe is first sampled.
- R4: Register 0 is read-only status: bit 0 is `mem_fail`, bit 1 is `irq`, and the other bits are 0. Register 1 reads as 0. Writes to register 0 have no effect.
- R5: A backend read holds `cpu_wait_n` low for max(4, 2+G+W) cycles, counted from the first strobe cycle. G is the number of request cycles before the grant (`mem_gnt_n`=0) is first seen. W is the number of cycles `mem_wait_n` is held low, starting from the grant cycle.
- R6: A backend write holds `cpu_wait_n` low for max(3, 2+G+W) cycles, with G and W defined as in R5.
- R7: `mem_req_n` goes low in the cycle after the strobe is sampled. It stays low up to and including the cycle in which the grant is first sampled. From that first request cycle, `mem_addr` carries the CPU address. On a read `mem_rd_n` is 0. On a write `mem_wr_n` equals `cpu_wr_n` and `mem_wdata` equals `cpu_din`.
- R8: When a backend read completes, `cpu_dout` holds the backend read data and `cpu_den`=1, starting in the first cycle with `cpu_wait_n`=1. Both stay so while the strobe is held.
- R9: If a backend transfer is not complete after 16 request cycles, it is aborted. `cpu_wait_n` is released after 17 low cycles, a read returns 0x0000, and `mem_fail` and `irq` go to 1 in that same released cycle.
- R10: `mem_fail` and `irq` stay set until any write to register 1, which clears both.
- R11: `cpu_den` is 0 whenever no read data is being presented. It falls in the cycle after the read strobe is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cpu_cs_n | input | 1 | CPU chip select, active low |
| cpu_wr_n | input | 2 | Byte-lane write strobes, active low (bit 1: 15:8, bit 0: 7:0) |
| cpu_rd_n | input | 1 | CPU read strobe, active low |
| cpu_mem_sel | input | 1 | 0: internal register, 1: backend memory |
| cpu_addr | input | 16 | CPU address |
| cpu_din | input | 16 | CPU write data |
| cpu_dout | output | 16 | Read data to the CPU |
| cpu_den | output | 1 | High while read data is presented |
| cpu_wait_n | output | 1 | CPU stall, active low |
| mem_req_n | output | 1 | Backend request, active low |
| mem_gnt_n | input | 1 | Backend grant, active low |
| mem_wait_n | input | 1 | Backend wait, active low |
| mem_addr | output | 16 | Backend address |
| mem_wdata | output | 16 | Backend write data |
| mem_rdata | input | 16 | Backend read data |
| mem_rd_n | output | 1 | Backend read strobe, active low |
| mem_wr_n | output | 2 | Backend byte-lane write strobes, active low |
| mem_fail | output | 1 | Sticky backend timeout flag |
| irq | output | 1 | Interrupt request, active high |

## Verification
Backend transfers are run with zero grant delay and no backend wait, which isolates the fixed read and write minimums. They are also run with combined grant delays and wait lengths that push completion past the minimum, which shows whether both delays add in the stall length. Two cases drive the backend beyond the limit, once through a grant that never comes and once through an endless backend wait, to tell the timeout path apart from normal completion. Register traffic uses each single byte lane and both lanes together, and includes writes to the read-only status register, so that lane masking, decode and the flag-clear register can each be seen on their own.

// File: rtl/hb_pkg.sv
package hb_pkg;
  localparam int HB_DW    = 16;
  localparam int HB_AW    = 16;
  localparam int HB_LANES = HB_DW / 8;

  typedef enum logic [1:0] {
    SQ_IDLE,
    SQ_BUSY,
    SQ_DONE
  } seq_state_t;

  typedef struct packed {
    logic                is_rd;
    logic [HB_AW-1:0]    addr;
    logic [HB_DW-1:0]    wdata;
    logic [HB_LANES-1:0] be_n;
  } mem_cmd_t;
endpackage

// File: rtl/hb_reg_bank.sv
module hb_reg_bank
  import hb_pkg::*;
#(
  parameter int NREG = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     we,
  input  logic [$clog2(NREG)-1:0]  idx,
  input  logic [HB_DW-1:0]         wdata,
  input  logic [HB_LANES-1:0]      lane_we,
  input  logic [HB_DW-1:0]         status,
  output logic [HB_DW-1:0]         rdata
);
  localparam int IW = $clog2(NREG);
  localparam logic [IW-1:0] FIRST_RW = IW'(2);

  logic [HB_DW-1:0] regs [NREG];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int r = 0; r < NREG; r++) regs[r] <= '0;
    end else if (we && idx >= FIRST_RW) begin
      for (int b = 0; b < HB_LANES; b++) begin
        if (lane_we[b]) regs[idx][b*8 +: 8] <= wdata[b*8 +: 8];
      end
    end
  end

  always_comb begin
    if (idx == '0)               rdata = status;
    else if (idx < FIRST_RW)     rdata = '0;
    else                         rdata = regs[idx];
  end

  // a masked lane keeps its old contents
  assert_lane_keep_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (we && idx >= FIRST_RW && !lane_we[0]) |=> $stable(regs[$past(idx)][7:0]));
endmodule

// File: rtl/hb_flags.sv
module hb_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic fail_o,
  output logic irq_o
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fail_o <= 1'b0;
      irq_o  <= 1'b0;
    end else if (set_i) begin
      fail_o <= 1'b1;
      irq_o  <= 1'b1;
    end else if (clr_i) begin
      fail_o <= 1'b0;
      irq_o  <= 1'b0;
    end
  end

  assert_fail_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (fail_o && !clr_i) |=> fail_o);

  assert_flags_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !set_i) |=> (!fail_o && !irq_o));
endmodule

// File: rtl/hb_mem_seq.sv
module hb_mem_seq
  import hb_pkg::*;
#(
  parameter int MIN_RD  = 4,
  parameter int MIN_WR  = 3,
  parameter int TIMEOUT = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic                hold,
  input  logic                start_rd,
  input  logic [HB_AW-1:0]    addr_i,
  input  logic [HB_DW-1:0]    wdata_i,
  input  logic [HB_LANES-1:0] be_n_i,
  input  logic                gnt_n,
  input  logic                bwait_n,
  input  logic [HB_DW-1:0]    rdata_i,
  output logic                idle,
  output logic                wait_n,
  output logic                req_n,
  output logic                rd_n,
  output logic [HB_LANES-1:0] wr_n,
  output logic [HB_AW-1:0]    addr_o,
  output logic [HB_DW-1:0]    wdata_o,
  output logic                cap,
  output logic [HB_DW-1:0]    cap_data,
  output logic                den_next,
  output logic                expire
);
  localparam int CW = $clog2(TIMEOUT + 1);

  seq_state_t     st, st_nx;
  mem_cmd_t       cmd;
  logic [CW-1:0]  cnt;
  logic [CW-1:0]  need;
  logic           gnt_seen;
  logic           launch;
  logic           complete;

  assign launch   = (st == SQ_IDLE) && start;
  assign need     = cmd.is_rd ? CW'(MIN_RD - 1) : CW'(MIN_WR - 1);
  assign complete = (st == SQ_BUSY) && (gnt_seen || !gnt_n) && bwait_n && (cnt >= need);
  assign expire   = (st == SQ_BUSY) && !complete && (cnt == CW'(TIMEOUT));

  always_comb begin
    st_nx = st;
    unique case (st)
      SQ_IDLE: if (start)               st_nx = SQ_BUSY;
      SQ_BUSY: if (complete || expire)  st_nx = SQ_DONE;
      SQ_DONE: if (!hold)               st_nx = SQ_IDLE;
      default:                          st_nx = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= SQ_IDLE;
      cnt      <= '0;
      gnt_seen <= 1'b0;
      cmd      <= '0;
      req_n    <= 1'b1;
      rd_n     <= 1'b1;
      wr_n     <= '1;
    end else begin
      st <= st_nx;
      if (launch) begin
        cnt       <= CW'(1);
        gnt_seen  <= 1'b0;
        cmd.is_rd <= start_rd;
        cmd.addr  <= addr_i;
        cmd.wdata <= wdata_i;
        cmd.be_n  <= be_n_i;
        req_n     <= 1'b0;
        rd_n      <= !start_rd;
        wr_n      <= start_rd ? '1 : be_n_i;
      end else if (st == SQ_BUSY) begin
        if (!gnt_n) gnt_seen <= 1'b1;
        if (!gnt_n || complete || expire) req_n <= 1'b1;
        if (complete || expire) begin
          rd_n <= 1'b1;
          wr_n <= '1;
        end else begin
          cnt <= cnt + CW'(1);
        end
      end
    end
  end

  assign idle     = (st == SQ_IDLE);
  assign wait_n   = !(launch || (st == SQ_BUSY));
  assign addr_o   = cmd.addr;
  assign wdata_o  = cmd.wdata;
  assign cap      = (complete || expire) && cmd.is_rd;
  assign cap_data = complete ? rdata_i : '0;
  assign den_next = (st_nx == SQ_DONE) && cmd.is_rd;

  assert_min_wait_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (st == SQ_DONE && $past(st) == SQ_BUSY) |-> ($past(cnt) >= $past(need)));

  assert_req_until_gnt_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (st == SQ_BUSY && !req_n && gnt_n && !complete && !expire) |=> !req_n);

  assert_cmd_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (st == SQ_BUSY && $past(st) == SQ_BUSY) |-> $stable(addr_o));

  assert_timeout_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (st == SQ_BUSY) |-> (cnt <= CW'(TIMEOUT)));
endmodule

// File: rtl/hb_cpu_bridge.sv
module hb_cpu_bridge
  import hb_pkg::*;
#(
  parameter int NREG    = 8,
  parameter int MIN_RD  = 4,
  parameter int MIN_WR  = 3,
  parameter int TIMEOUT = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cpu_cs_n,
  input  logic [HB_LANES-1:0] cpu_wr_n,
  input  logic                cpu_rd_n,
  input  logic                cpu_mem_sel,
  input  logic [HB_AW-1:0]    cpu_addr,
  input  logic [HB_DW-1:0]    cpu_din,
  output logic [HB_DW-1:0]    cpu_dout,
  output logic                cpu_den,
  output logic                cpu_wait_n,
  output logic                mem_req_n,
  input  logic                mem_gnt_n,
  input  logic                mem_wait_n,
  output logic [HB_AW-1:0]    mem_addr,
  output logic [HB_DW-1:0]    mem_wdata,
  input  logic [HB_DW-1:0]    mem_rdata,
  output logic                mem_rd_n,
  output logic [HB_LANES-1:0] mem_wr_n,
  output logic                mem_fail,
  output logic                irq
);
  localparam int IW = $clog2(NREG);
  localparam logic [IW-1:0] CLR_IDX = IW'(1);

  logic                rd_act, wr_act, acc_act;
  logic                reg_rd, reg_wr, mem_go;
  logic [HB_LANES-1:0] lane_we;
  logic [HB_DW-1:0]    reg_rdata, status;
  logic                seq_idle, seq_cap, seq_den_nx, seq_expire;
  logic [HB_DW-1:0]    seq_cap_data;
  logic                flag_clr;

  assign rd_act  = !cpu_cs_n && !cpu_rd_n;
  assign wr_act  = !cpu_cs_n && (cpu_wr_n != '1);
  assign acc_act = rd_act || wr_act;
  assign reg_rd  = rd_act && !cpu_mem_sel && seq_idle;
  assign reg_wr  = wr_act && !cpu_mem_sel && seq_idle;
  assign mem_go  = acc_act && cpu_mem_sel;

  for (genvar b = 0; b < HB_LANES; b++) begin : g_lane
    assign lane_we[b] = !cpu_wr_n[b];
  end

  assign flag_clr = reg_wr && (cpu_addr[IW-1:0] == CLR_IDX);
  assign status   = {{(HB_DW-2){1'b0}}, irq, mem_fail};

  hb_reg_bank #(.NREG(NREG)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .we      (reg_wr),
    .idx     (cpu_addr[IW-1:0]),
    .wdata   (cpu_din),
    .lane_we (lane_we),
    .status  (status),
    .rdata   (reg_rdata)
  );

  hb_mem_seq #(.MIN_RD(MIN_RD), .MIN_WR(MIN_WR), .TIMEOUT(TIMEOUT)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (mem_go),
    .hold     (acc_act),
    .start_rd (rd_act),
    .addr_i   (cpu_addr),
    .wdata_i  (cpu_din),
    .be_n_i   (cpu_wr_n),
    .gnt_n    (mem_gnt_n),
    .bwait_n  (mem_wait_n),
    .rdata_i  (mem_rdata),
    .idle     (seq_idle),
    .wait_n   (cpu_wait_n),
    .req_n    (mem_req_n),
    .rd_n     (mem_rd_n),
    .wr_n     (mem_wr_n),
    .addr_o   (mem_addr),
    .wdata_o  (mem_wdata),
    .cap      (seq_cap),
    .cap_data (seq_cap_data),
    .den_next (seq_den_nx),
    .expire   (seq_expire)
  );

  hb_flags u_flags (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_i  (seq_expire),
    .clr_i  (flag_clr),
    .fail_o (mem_fail),
    .irq_o  (irq)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cpu_dout <= '0;
      cpu_den  <= 1'b0;
    end else begin
      if (reg_rd)       cpu_dout <= reg_rdata;
      else if (seq_cap) cpu_dout <= seq_cap_data;
      cpu_den <= reg_rd || seq_den_nx;
    end
  end

  assert_den_after_read_R11: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_den |-> $past(rd_act));

  assert_reg_no_wait_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_act && !cpu_mem_sel && seq_idle) |-> cpu_wait_n);

  assert_fail_irq_pair_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_fail) |-> irq);
endmodule

// File: tb/hb_cpu_bridge_test.sv
module hb_cpu_bridge_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cpu_cs_n, cpu_rd_n, cpu_mem_sel;
  logic [1:0]  cpu_wr_n;
  logic [15:0] cpu_addr, cpu_din;
  logic [15:0] cpu_dout;
  logic        cpu_den, cpu_wait_n;
  logic        mem_req_n, mem_gnt_n, mem_wait_n, mem_rd_n;
  logic [15:0] mem_addr, mem_wdata, mem_rdata;
  logic [1:0]  mem_wr_n;
  logic        mem_fail, irq;

  int compared = 0;
  int mismatched = 0;
  bit finished = 0;

  logic [15:0] mreg [8];
  bit mfail = 0;
  bit mirq = 0;

  always #4 clk = ~clk;

  assign mem_rdata = mem_addr ^ 16'h5A3C;

  hb_cpu_bridge uut (
    .clk(clk), .rst_n(rst_n), .cpu_cs_n(cpu_cs_n), .cpu_wr_n(cpu_wr_n),
    .cpu_rd_n(cpu_rd_n), .cpu_mem_sel(cpu_mem_sel), .cpu_addr(cpu_addr),
    .cpu_din(cpu_din), .cpu_dout(cpu_dout), .cpu_den(cpu_den),
    .cpu_wait_n(cpu_wait_n), .mem_req_n(mem_req_n), .mem_gnt_n(mem_gnt_n),
    .mem_wait_n(mem_wait_n), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_rd_n(mem_rd_n), .mem_wr_n(mem_wr_n),
    .mem_fail(mem_fail), .irq(irq)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] exp_reg(int idx);
    if (idx == 0) return {14'b0, mirq, mfail};
    if (idx == 1) return 16'h0000;
    return mreg[idx];
  endfunction

  function automatic int last_req_cycle(bit rd, int g, int w);
    int mn = rd ? 4 : 3;
    int js = (mn - 1 > 1 + g + w) ? mn - 1 : 1 + g + w;
    return (js > 16) ? 16 : js;
  endfunction

  task automatic idle_bus();
    cpu_cs_n = 1'b1; cpu_rd_n = 1'b1; cpu_wr_n = 2'b11;
    cpu_mem_sel = 1'b0;
    mem_gnt_n = 1'b1; mem_wait_n = 1'b1;
  endtask

  task automatic reg_write(int idx, logic [15:0] d, logic [1:0] wn);
    @(negedge clk);
    cpu_cs_n = 1'b0; cpu_mem_sel = 1'b0; cpu_addr = 16'(idx); cpu_din = d; cpu_wr_n = wn;
    #1 chk("R3 no wait on register write", cpu_wait_n, 1);
    @(negedge clk);
    idle_bus();
    if (idx >= 2) begin
      if (!wn[1]) mreg[idx][15:8] = d[15:8];
      if (!wn[0]) mreg[idx][7:0]  = d[7:0];
    end else if (idx == 1) begin
      mfail = 0; mirq = 0;
    end
  endtask

  task automatic reg_read(int idx, string tag);
    @(negedge clk);
    cpu_cs_n = 1'b0; cpu_mem_sel = 1'b0; cpu_addr = 16'(idx); cpu_rd_n = 1'b0;
    #1 chk("R3 no wait on register read", cpu_wait_n, 1);
    @(negedge clk);
    #1;
    chk(tag, cpu_dout, exp_reg(idx));
    chk("R3 den with register data", cpu_den, 1);
    idle_bus();
    @(negedge clk);
    #1 chk("R11 den drops after release", cpu_den, 0);
  endtask

  task automatic mem_op(bit rd, logic [15:0] a, logic [15:0] d, logic [1:0] be, int g, int w);
    int je = last_req_cycle(rd, g, w);
    bit to = ((rd ? 3 : 2) > 16) || (1 + g + w > 16);
    bit done = 0;
    @(negedge clk);
    cpu_cs_n = 1'b0; cpu_mem_sel = 1'b1; cpu_addr = a; cpu_din = d;
    if (rd) cpu_rd_n = 1'b0; else cpu_wr_n = be;
    #1 chk("R5 wait low in strobe cycle", cpu_wait_n, 0);
    for (int j = 1; j <= 40 && !done; j++) begin
      @(negedge clk);
      mem_gnt_n  = (j >= 1 + g) ? 1'b0 : 1'b1;
      mem_wait_n = (j >= 1 + g && j < 1 + g + w) ? 1'b0 : 1'b1;
      #1;
      if (cpu_wait_n) begin
        done = 1;
        if (to) begin
          mfail = 1; mirq = 1;
          chk("R9 timeout wait length", j, 17);
        end else if (rd) begin
          chk("R5 read wait length", j, je + 1);
        end else begin
          chk("R6 write wait length", j, je + 1);
        end
        if (rd) begin
          chk(to ? "R9 aborted read returns zero" : "R8 read data", cpu_dout,
              to ? 16'h0000 : (a ^ 16'h5A3C));
          chk("R8 den with backend data", cpu_den, 1);
        end
        chk("R9 fail flag after access", mem_fail, mfail);
        chk("R10 irq after access", irq, mirq);
        chk("R7 request released when done", mem_req_n, 1);
      end else begin
        chk("R7 request held until grant", mem_req_n, (j <= 1 + g) ? 0 : 1);
        if (j == 1) begin
          chk("R7 backend address", mem_addr, a);
          if (rd) chk("R7 backend read strobe", mem_rd_n, 0);
          else begin
            chk("R7 backend byte strobes", mem_wr_n, be);
            chk("R7 backend write data", mem_wdata, d);
          end
        end
      end
    end
    if (!done) chk("R5 wait never released", 0, 1);
    idle_bus();
    @(negedge clk);
    #1;
    chk("R11 den low after backend access", cpu_den, 0);
    chk("R5 wait high after release", cpu_wait_n, 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      mismatched++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    for (int i = 0; i < 8; i++) mreg[i] = 16'h0000;
    rst_n = 1'b0; cpu_addr = '0; cpu_din = '0;
    idle_bus();
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 wait idle in reset", cpu_wait_n, 1);
    chk("R1 request idle in reset", mem_req_n, 1);
    chk("R1 den in reset", cpu_den, 0);
    chk("R1 dout in reset", cpu_dout, 0);
    chk("R1 flags in reset", {mem_fail, irq}, 0);
    chk("R1 backend strobes in reset", {mem_rd_n, mem_wr_n}, 3'b111);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 first cycle after reset", {cpu_wait_n, mem_req_n, cpu_den}, 3'b110);

    // directed register cases
    reg_write(2, 16'hBEEF, 2'b00);
    reg_read(2, "R2 full write readback");
    reg_write(2, 16'h1234, 2'b01);
    reg_read(2, "R2 upper lane only");
    reg_write(2, 16'h5678, 2'b10);
    reg_read(2, "R2 lower lane only");
    reg_write(7, 16'hA55A, 2'b00);
    reg_read(7, "R2 top register");
    reg_write(0, 16'hFFFF, 2'b00);
    reg_read(0, "R4 status ignores writes");
    reg_read(1, "R4 clear register reads zero");

    // directed backend cases
    mem_op(1, 16'h0100, 16'h0, 2'b11, 0, 0);
    mem_op(0, 16'h0200, 16'hC0DE, 2'b00, 0, 0);
    mem_op(1, 16'h0300, 16'h0, 2'b11, 3, 2);
    mem_op(0, 16'h0400, 16'h7777, 2'b01, 1, 4);
    mem_op(1, 16'h0500, 16'h0, 2'b11, 30, 0);
    reg_read(0, "R4 status shows timeout flags");
    reg_write(3, 16'h0F0F, 2'b00);
    chk("R10 flags survive other writes", {mem_fail, irq}, 2'b11);
    reg_write(1, 16'h0000, 2'b10);
    chk("R10 flags cleared by register 1", {mem_fail, irq}, 2'b00);
    mem_op(0, 16'h0600, 16'h1111, 2'b00, 0, 20);
    reg_write(1, 16'h0000, 2'b00);
    mem_op(1, 16'h0700, 16'h0, 2'b11, 0, 14);

    // constrained random traffic
    for (int k = 0; k < 60; k++) begin
      int op = $urandom_range(0, 3);
      int idx = $urandom_range(0, 7);
      logic [15:0] dv = 16'($urandom);
      case (op)
        0: reg_write(idx, dv, 2'($urandom_range(0, 2)));
        1: reg_read(idx, "R2 random register readback");
        default: begin
          int g = $urandom_range(0, 6);
          int w = $urandom_range(0, 5);
          if ($urandom_range(0, 9) == 0) g = 18;
          if (op == 2) mem_op(1, 16'($urandom), dv, 2'b11, g, w);
          else         mem_op(0, 16'($urandom), dv, 2'($urandom_range(0, 2)), g, w);
        end
      endcase
    end
    reg_read(0, "R4 final status");

    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule